// File: doc/BRIEF.md
# Pixel ADC Dark-Level Offset Calibrator

This block sets the offset trim of a single pixel's ADC from dark measurements. After a start pulse it steps the trim setting from zero upward, one step per group of accepted ADC samples, where each step moves the pixel's zero-signal level by about a tenth of a bin. Each group is sorted into "below", "in" or "above" the chosen target bin. From those group results it picks the trim value that puts the zero-signal level into the target bin, and then holds that value on its output.

Two selection methods are offered. The edge method suits pixels whose noise is much smaller than a bin. It finds the first setting at which the output enters the target bin from below and the last setting before it leaves the bin upward, and then returns the midpoint of the two. The peak method suits noisier pixels. It sweeps the whole trim range and returns the setting whose group holds the most samples in the target bin. When the edge method cannot find both edges, the block raises a failure flag and returns the middle of the trim range. In a full calibration this offset step runs before gain adjustment, and it may be run a second time afterwards.

Top module: `offset_cal_engine`

## Requirements
- R1: While reset is asserted and after it is released, trim_out is 0 and busy, done and fail are all 0.
- R2: A start pulse taken while the block is not busy raises busy and sets trim_out to 0. group_len is latched at that point as the group size N, and a value of 0 is treated as 1. The block counts only cycles with adc_valid high, and trim_out rises by exactly 1 after each group of N counted samples.
- R3: While busy, trim_out changes only on the clock edge that takes the last sample of a group. It never changes in the middle of a group.
- R4: A group is "in" when 2*hits > N, where hits is the number of samples equal to target_bin. Otherwise it is "above" when more of its samples exceed target_bin than fall below it, and "below" in every other case.
- R5: With method = 0 (edge), the lower edge is the first "in" setting that follows an earlier "below" group. The upper edge is the last "in" setting before the first "above" group that comes after the lower edge. The sweep stops at that "above" group, and the result is floor((lower + upper) / 2).
- R6: With method = 0, if the sweep reaches the top trim value without finding both edges, fail is set to 1 and the result is the centre value 2^(TRIM_W-1).
- R7: With method = 1 (peak), all 2^TRIM_W settings are swept. The result is the setting with the most hits; a tie keeps the earlier setting, and if no setting has any hits the result is 0. fail stays 0.
- R8: done rises, and busy falls, two clock edges after the edge that takes the final sample. done, fail and the result on trim_out then hold, whatever arrives on the ADC inputs, until the next start, which clears done and fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a calibration |
| method | input | 1 | 0 = edge method, 1 = peak method |
| target_bin | input | CODE_W | ADC code that the zero-signal level should land in |
| group_len | input | CNT_W | Number of samples per trim setting (0 is treated as 1) |
| adc_valid | input | 1 | Qualifies adc_code |
| adc_code | input | CODE_W | Dark ADC conversion result |
| trim_out | output | TRIM_W | Offset trim value to apply to the pixel |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Result valid; held until the next start |
| fail | output | 1 | Edge method could not find both edges |

## Verification
A wrong sample counter or a wrong group boundary shows within the first group: trim_out steps away from the sample index divided by N, and the bench compares those at every sample it drives. A wrong classification or wrong edge tracking stays hidden during the sweep and appears only in the final trim and fail values, two edges after the final sample. The bench therefore drives pixel models with a known answer, both noiseless and dithered. These include pixels that start inside the bin, never leave it, or never reach it, and the bench compares each result as soon as done rises.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    GRP_BELOW = 2'd0,
    GRP_IN    = 2'd1,
    GRP_ABOVE = 2'd2
  } grp_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EVAL = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/cal_tally.sv
module cal_tally
  import cal_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [CODE_W-1:0] target,
  input  logic [CNT_W-1:0]  n_last,
  output logic              grp_done,
  output grp_class_e        grp_class,
  output logic [CNT_W-1:0]  grp_hits
);

  localparam int SUM_W = CNT_W + 2;

  logic [CNT_W-1:0] smp_q, hit_q, abv_q, blw_q;
  logic [CNT_W-1:0] smp_d, hit_d, abv_d, blw_d;
  logic [CNT_W-1:0] hit_n, abv_n, blw_n;
  logic [SUM_W-1:0] twice_hit, n_full;
  logic             take, last, cnt_en;

  always_comb begin
    take      = run & adc_valid;
    last      = (smp_q == n_last);
    grp_done  = take & last;
    hit_n     = hit_q + CNT_W'(adc_code == target);
    abv_n     = abv_q + CNT_W'(adc_code >  target);
    blw_n     = blw_q + CNT_W'(adc_code <  target);
    grp_hits  = hit_n;
    twice_hit = {1'b0, hit_n, 1'b0};
    n_full    = SUM_W'(n_last) + SUM_W'(1);
    if (twice_hit > n_full)  grp_class = GRP_IN;
    else if (abv_n > blw_n)  grp_class = GRP_ABOVE;
    else                     grp_class = GRP_BELOW;
  end

  always_comb begin
    cnt_en = clr | take;
    smp_d  = smp_q;
    hit_d  = hit_q;
    abv_d  = abv_q;
    blw_d  = blw_q;
    if (clr || (take && last)) begin
      smp_d = '0;
      hit_d = '0;
      abv_d = '0;
      blw_d = '0;
    end else if (take) begin
      smp_d = smp_q + CNT_W'(1);
      hit_d = hit_n;
      abv_d = abv_n;
      blw_d = blw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      hit_q <= '0;
      abv_q <= '0;
      blw_q <= '0;
    end else if (cnt_en) begin
      smp_q <= smp_d;
      hit_q <= hit_d;
      abv_q <= abv_d;
      blw_q <= blw_d;
    end
  end

  // R2
  smp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (smp_q <= n_last));

endmodule

// File: rtl/cal_pick.sv
module cal_pick
  import cal_pkg::*;
#(
  parameter int TRIM_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              grp_done,
  input  grp_class_e        grp_class,
  input  logic [CNT_W-1:0]  grp_hits,
  input  logic [TRIM_W-1:0] trim_cur,
  input  logic              method,
  output logic              stop_now,
  output logic              bnd_ok,
  output logic [TRIM_W-1:0] bnd_mid,
  output logic [TRIM_W-1:0] best_trim
);

  logic              seen_blw_q, have_lo_q, up_q;
  logic              seen_blw_d, have_lo_d, up_d;
  logic [TRIM_W-1:0] lo_q, hi_q, best_q;
  logic [TRIM_W-1:0] lo_d, hi_d, best_d;
  logic [CNT_W-1:0]  best_hits_q, best_hits_d;
  logic [TRIM_W:0]   mid_sum;
  logic              upd_en;

  always_comb begin
    stop_now  = grp_done && !method && (grp_class == GRP_ABOVE) && have_lo_q;
    bnd_ok    = have_lo_q & up_q;
    mid_sum   = {1'b0, lo_q} + {1'b0, hi_q};
    bnd_mid   = mid_sum[TRIM_W:1];
    best_trim = best_q;
  end

  always_comb begin
    upd_en      = clr | grp_done;
    seen_blw_d  = seen_blw_q;
    have_lo_d   = have_lo_q;
    up_d        = up_q;
    lo_d        = lo_q;
    hi_d        = hi_q;
    best_d      = best_q;
    best_hits_d = best_hits_q;
    if (clr) begin
      seen_blw_d  = 1'b0;
      have_lo_d   = 1'b0;
      up_d        = 1'b0;
      lo_d        = '0;
      hi_d        = '0;
      best_d      = '0;
      best_hits_d = '0;
    end else if (grp_done) begin
      if (!method) begin
        unique case (grp_class)
          GRP_BELOW: seen_blw_d = 1'b1;
          GRP_IN: begin
            if (!have_lo_q && seen_blw_q) begin
              have_lo_d = 1'b1;
              lo_d      = trim_cur;
            end
            if (have_lo_q || seen_blw_q) hi_d = trim_cur;
          end
          GRP_ABOVE: if (have_lo_q) up_d = 1'b1;
          default: ;
        endcase
      end else if (grp_hits > best_hits_q) begin
        best_d      = trim_cur;
        best_hits_d = grp_hits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_blw_q  <= 1'b0;
      have_lo_q   <= 1'b0;
      up_q        <= 1'b0;
      lo_q        <= '0;
      hi_q        <= '0;
      best_q      <= '0;
      best_hits_q <= '0;
    end else if (upd_en) begin
      seen_blw_q  <= seen_blw_d;
      have_lo_q   <= have_lo_d;
      up_q        <= up_d;
      lo_q        <= lo_d;
      hi_q        <= hi_d;
      best_q      <= best_d;
      best_hits_q <= best_hits_d;
    end
  end

  // R5
  edge_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have_lo_q |-> (lo_q <= hi_q));

  // R7
  best_not_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    best_q <= trim_cur);

endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int TRIM_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              method_in,
  input  logic [CODE_W-1:0] target_in,
  input  logic [CNT_W-1:0]  n_in,
  input  logic              grp_done,
  input  logic              stop_now,
  input  logic              bnd_ok,
  input  logic [TRIM_W-1:0] bnd_mid,
  input  logic [TRIM_W-1:0] best_trim,
  output logic              clr,
  output logic              run,
  output logic              meth,
  output logic [CODE_W-1:0] target,
  output logic [CNT_W-1:0]  n_last,
  output logic [TRIM_W-1:0] trim,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam logic [TRIM_W-1:0] CENTRE   = TRIM_W'(1) << (TRIM_W - 1);

  seq_state_e        state_q, state_d;
  logic [TRIM_W-1:0] trim_q, trim_d;
  logic              fail_q, fail_d, meth_q, meth_d;
  logic [CODE_W-1:0] tgt_q, tgt_d;
  logic [CNT_W-1:0]  nlast_q, nlast_d;
  logic              accept;

  always_comb begin
    accept  = start && ((state_q == ST_IDLE) || (state_q == ST_FIN));
    state_d = state_q;
    trim_d  = trim_q;
    fail_d  = fail_q;
    meth_d  = meth_q;
    tgt_d   = tgt_q;
    nlast_d = nlast_q;
    unique case (state_q)
      ST_IDLE, ST_FIN: begin
        if (accept) begin
          state_d = ST_RUN;
          trim_d  = '0;
          fail_d  = 1'b0;
          meth_d  = method_in;
          tgt_d   = target_in;
          nlast_d = (n_in == '0) ? '0 : n_in - CNT_W'(1);
        end
      end
      ST_RUN: begin
        if (grp_done) begin
          if (stop_now || (trim_q == TRIM_MAX)) state_d = ST_EVAL;
          else                                  trim_d  = trim_q + TRIM_W'(1);
        end
      end
      ST_EVAL: begin
        state_d = ST_FIN;
        if (meth_q)      trim_d = best_trim;
        else if (bnd_ok) trim_d = bnd_mid;
        else begin
          trim_d = CENTRE;
          fail_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trim_q  <= '0;
      fail_q  <= 1'b0;
      meth_q  <= 1'b0;
      tgt_q   <= '0;
      nlast_q <= '0;
    end else begin
      state_q <= state_d;
      trim_q  <= trim_d;
      fail_q  <= fail_d;
      if (accept) begin
        meth_q  <= meth_d;
        tgt_q   <= tgt_d;
        nlast_q <= nlast_d;
      end
    end
  end

  always_comb begin
    clr    = accept;
    run    = (state_q == ST_RUN);
    meth   = meth_q;
    target = tgt_q;
    n_last = nlast_q;
    trim   = trim_q;
    busy   = (state_q == ST_RUN) || (state_q == ST_EVAL);
    done   = (state_q == ST_FIN);
    fail   = fail_q;
  end

  // R3
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !grp_done) |=> $stable(trim_q));

  // R2
  trim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && grp_done && !stop_now && trim_q != TRIM_MAX)
      |=> (trim_q == $past(trim_q) + TRIM_W'(1)));

  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R6
  fail_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> (done && trim_q == CENTRE && !meth_q));

endmodule

// File: rtl/offset_cal_engine.sv
module offset_cal_engine
  import cal_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int TRIM_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              method,
  input  logic [CODE_W-1:0] target_bin,
  input  logic [CNT_W-1:0]  group_len,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  output logic [TRIM_W-1:0] trim_out,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  logic              clr, run, meth, grp_done, stop_now, bnd_ok;
  logic [CODE_W-1:0] tgt;
  logic [CNT_W-1:0]  n_last, grp_hits;
  logic [TRIM_W-1:0] bnd_mid, best_trim, trim_cur;
  grp_class_e        grp_class;

  cal_seq #(.CODE_W(CODE_W), .TRIM_W(TRIM_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .method_in(method),
    .target_in(target_bin), .n_in(group_len), .grp_done(grp_done),
    .stop_now(stop_now), .bnd_ok(bnd_ok), .bnd_mid(bnd_mid),
    .best_trim(best_trim), .clr(clr), .run(run), .meth(meth),
    .target(tgt), .n_last(n_last), .trim(trim_cur), .busy(busy),
    .done(done), .fail(fail)
  );

  cal_tally #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .adc_valid(adc_valid),
    .adc_code(adc_code), .target(tgt), .n_last(n_last),
    .grp_done(grp_done), .grp_class(grp_class), .grp_hits(grp_hits)
  );

  cal_pick #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .grp_done(grp_done),
    .grp_class(grp_class), .grp_hits(grp_hits), .trim_cur(trim_cur),
    .method(meth), .stop_now(stop_now), .bnd_ok(bnd_ok),
    .bnd_mid(bnd_mid), .best_trim(best_trim)
  );

  assign trim_out = trim_cur;

endmodule

// File: tb/offset_cal_engine_tb.sv
module offset_cal_engine_tb;

  logic       clk = 1'b0;
  logic       rst_n, start, method, adc_valid;
  logic [7:0] target_bin, adc_code;
  logic [4:0] group_len;
  logic [3:0] trim_out;
  logic       busy, done, fail;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 1'b0;
  int    exp_trim_q[$];
  int    exp_fail_q[$];
  string exp_tag_q[$];

  always #10 clk = ~clk;

  offset_cal_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .method(method),
    .target_bin(target_bin), .group_len(group_len), .adc_valid(adc_valid),
    .adc_code(adc_code), .trim_out(trim_out), .busy(busy), .done(done),
    .fail(fail)
  );

  task automatic chk(string req, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Dark pixel model: level in tenths of a bin, optional 7-step dither.
  function automatic int code_of(int t, int j, int base, bit noisy);
    int v;
    v = base + t;
    if (noisy) v = v + (j % 7) - 3;
    if (v < 0) v = 0;
    return v / 10;
  endfunction

  // Expected result from the requirements (R4..R7).
  function automatic void ref_model(input bit m, input int tgt, input int n,
                                    input int base, input bit noisy,
                                    output int r_trim, output int r_fail,
                                    output int r_smp);
    int neff, j, lo, hi, best, bh, hits, ab, bl, cls, c;
    bit seen, have_lo;
    neff = (n == 0) ? 1 : n;
    j = 0; lo = 0; hi = 0; best = 0; bh = 0; seen = 0; have_lo = 0;
    for (int t = 0; t < 16; t++) begin
      hits = 0; ab = 0; bl = 0;
      for (int k = 0; k < neff; k++) begin
        c = code_of(t, j, base, noisy);
        j++;
        if (c == tgt) hits++;
        else if (c > tgt) ab++;
        else bl++;
      end
      if (2 * hits > neff) cls = 1;
      else if (ab > bl)    cls = 2;
      else                 cls = 0;
      if (!m) begin
        if (cls == 0) seen = 1;
        if (cls == 1) begin
          if (!have_lo && seen) begin have_lo = 1; lo = t; end
          if (have_lo) hi = t;
        end
        if (cls == 2 && have_lo) begin
          r_trim = (lo + hi) / 2; r_fail = 0; r_smp = j;
          return;
        end
      end else if (hits > bh) begin
        bh = hits; best = t;
      end
    end
    r_smp = j;
    if (!m) begin r_trim = 8; r_fail = 1; end
    else    begin r_trim = best; r_fail = 0; end
  endfunction

  task automatic run_case(bit m, int tgt, int n, int base, bit noisy,
                          bit gap, string tag);
    int et, ef, ns, neff, j, cyc, held;
    ref_model(m, tgt, n, base, noisy, et, ef, ns);
    exp_trim_q.push_back(et);
    exp_fail_q.push_back(ef);
    exp_tag_q.push_back(tag);
    neff = (n == 0) ? 1 : n;
    @(negedge clk);
    method = m; target_bin = 8'(tgt); group_len = 5'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R8", "done cleared by start", int'(done), 0);
    j = 0; cyc = 0;
    while (j < ns) begin
      if (gap && (cyc % 3 == 2)) adc_valid = 1'b0;
      else begin
        adc_valid = 1'b1;
        adc_code  = 8'(code_of(int'(trim_out), j, base, noisy));
        if (j % neff == 0 || j % neff == neff - 1)
          chk("R3", "trim within group", int'(trim_out), j / neff);
        j++;
      end
      cyc++;
      @(negedge clk);
    end
    adc_valid = 1'b0;
    chk("R8", "done one edge after last sample", int'(done), 0);
    @(negedge clk);
    chk("R8", "done two edges after last sample", int'(done), 1);
    chk("R8", "busy cleared", int'(busy), 0);
    held = int'(trim_out);
    for (int k = 0; k < 4; k++) begin
      adc_valid = 1'b1;
      adc_code  = 8'(k * 3);
      @(negedge clk);
    end
    adc_valid = 1'b0;
    chk("R8", "result held after done", int'(trim_out), held);
    chk("R8", "done held", int'(done), 1);
  endtask

  // Monitor: compare each result as done rises.
  initial begin
    bit prev;
    int et, ef;
    string tg;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && done && !prev) begin
        if (exp_trim_q.size() == 0) chk("R8", "unexpected done", 1, 0);
        else begin
          et = exp_trim_q.pop_front();
          ef = exp_fail_q.pop_front();
          tg = exp_tag_q.pop_front();
          chk(tg, "result trim", int'(trim_out), et);
          chk(tg, "fail flag", int'(fail), ef);
        end
      end
      prev = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; method = 1'b0; adc_valid = 1'b0;
    target_bin = '0; adc_code = '0; group_len = '0;
    repeat (3) @(negedge clk);
    chk("R1", "trim in reset", int'(trim_out), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "fail in reset", int'(fail), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "trim after reset", int'(trim_out), 0);
    chk("R1", "done after reset", int'(done), 0);

    run_case(1'b0, 1, 1, 5, 1'b0, 1'b0, "R5");   // edges 5 and 14 -> 9
    run_case(1'b0, 1, 4, 5, 1'b0, 1'b1, "R5");   // gaps in valid, N=4
    run_case(1'b0, 1, 0, 5, 1'b0, 1'b0, "R2");   // N=0 acts as N=1
    run_case(1'b0, 1, 5, 3, 1'b1, 1'b1, "R5");   // dithered, majority rule R4
    run_case(1'b0, 1, 2, 0, 1'b0, 1'b0, "R6");   // never leaves bin upward
    run_case(1'b0, 0, 2, 5, 1'b0, 1'b0, "R6");   // starts inside bin
    run_case(1'b1, 1, 7, 5, 1'b1, 1'b0, "R7");   // dithered peak
    run_case(1'b1, 1, 3, 5, 1'b0, 1'b1, "R7");   // plateau: earliest wins
    run_case(1'b1, 3, 2, 5, 1'b0, 1'b0, "R7");   // no hits -> 0
    run_case(1'b1, 1, 5, 4, 1'b1, 1'b0, "R4");   // dither not group-aligned

    repeat (3) @(negedge clk);
    chk("R8", "all results seen", exp_trim_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule